// File: doc/BRIEF.md
# AES CCM/CTR Mode Sequencer

This block holds the mode logic around an external AES-128 block cipher. Software loads key slots, an initial vector, a reference tag and a block count. It then selects a mode and sets the start bit. The sequencer takes 128-bit data blocks, as four 32-bit words, from an input FIFO. It combines each block with a keystream from the external cipher and pushes four result words into an output FIFO. The cipher itself is reached through a valid/ready request port and a response strobe, with one block in flight at a time.

Two modes are supported. In counter mode, the counter starts from the stored vector. In CCM decryption, the sequencer builds a first counter block and a tag-seed block from a 12-byte nonce, keeps a running CBC-MAC over the recovered plaintext, and compares the final tag with the stored reference. Word order inside a block is little-endian, so a 128-bit register or block (word 0 in bits 31:0) is handed to the cipher as a big-endian number unchanged. This takes care of the byte reversal on the way in and on the way out. The pass/fail result of the tag check is a status bit. A one-cycle interrupt marks the end of a transfer.

Register addresses (word index on `reg_addr`): 0 control, 1 block count, 4 to 7 vector words 0 to 3, 8 to 11 reference tag words 0 to 3, and 16 + 4·slot + word for the four key slots.

Top module: `aes_ccm_seq`

## Requirements
- R1: After reset, `ctrl_rd` is 0, `in_full` is 0, `out_empty` is 1, `irq` is 0 and no cipher request is raised. The vector, tag and key-slot registers all read as zero, so a first transfer uses a zero key and a zero counter.
- R2: Control bit 31 starts a transfer only when it is written as 1 while it reads 0. It reads 1 until the transfer completes. Any control write made while it reads 1 is ignored. The block count is taken from bits 31:16 of the block-count register at the start.
- R3: With control bit 29 set (modes 2 and 3), the counter is the 128-bit vector register. Each block's output is the input block XOR the cipher of the counter, and the counter then increments by one. Bit 21 reads 0 after completion.
- R4: Writing control bit 24 as 1 copies key slot bits 27:26 into the key presented on `aes_req_key`. Bit 24 itself reads 0.
- R5: In CCM (bit 29 clear), the first cipher request is the seed block. Its byte 0 is 0x02 OR (tag length << 3) OR (0x40 when block-count bits 15:0 are nonzero). Bytes 1 to 12 are vector bits 95:0. Bytes 13 to 15 are the block count << 4.
- R6: In CCM, the first data counter is 0x02, then the nonce, then 0x000001. Each output block is input XOR the cipher of that counter, and the counter increments by one per block.
- R7: In CCM, each block adds the plaintext into the running MAC, and the sum is sent to the cipher. A transfer of N blocks makes exactly 2N+2 cipher requests.
- R8: At the end of CCM, the MAC is XORed with the cipher of the counter whose low three bytes are zero. Bit 21 is 1 exactly when that result equals the reference-tag register.
- R9: A tag-length field (control bits 18:16) of 0 builds the seed block as if it were 1.
- R10: Vector, tag, block-count and key writes change only the bytes selected by `reg_be`.
- R11: A block is consumed only while the input FIFO holds at least four words and the output FIFO has at least four free places. Otherwise the transfer stalls with bit 31 still set.
- R12: At completion, `irq` pulses for exactly one cycle if control bit 30 is set, and stays low otherwise.
- R13: A cipher request keeps `aes_req_valid` and `aes_req_blk` stable until it is accepted. A new request is raised only after the previous response has returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_be | input | 4 | Byte-lane enables for the write |
| ctrl_rd | output | 32 | Control and status register value |
| in_wr | input | 1 | Push a word into the input FIFO |
| in_data | input | 32 | Input FIFO word |
| in_full | output | 1 | Input FIFO full |
| out_rd | input | 1 | Pop a word from the output FIFO |
| out_data | output | 32 | Head word of the output FIFO |
| out_empty | output | 1 | Output FIFO empty |
| aes_req_valid | output | 1 | Cipher request valid |
| aes_req_ready | input | 1 | Cipher accepts the request |
| aes_req_key | output | 128 | Key for the request |
| aes_req_blk | output | 128 | Block to encrypt |
| aes_rsp_valid | input | 1 | Cipher result strobe |
| aes_rsp_blk | input | 128 | Cipher result |
| irq | output | 1 | Completion pulse |

## Verification
The hardest state to reach is a transfer that stops in the middle because the output FIFO is full. The data is all present and the transfer is still busy, yet no new cipher request may appear. The bench starts a five-block counter-mode run and feeds all twenty words without reading anything out. After a long wait, it checks that exactly four requests were made and that a control write during the stall changed nothing. It then drains the FIFO and checks the remaining output. The tag check is driven both ways by writing the exact tag the bench computes from a stand-in cipher function, or that tag with one bit flipped.

// File: rtl/aes_ccm_seq.sv
module aes_ccm_seq #(
  parameter int FDEPTH = 16
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_wr,
  input  logic [4:0]   reg_addr,
  input  logic [31:0]  reg_wdata,
  input  logic [3:0]   reg_be,
  output logic [31:0]  ctrl_rd,
  input  logic         in_wr,
  input  logic [31:0]  in_data,
  output logic         in_full,
  input  logic         out_rd,
  output logic [31:0]  out_data,
  output logic         out_empty,
  output logic         aes_req_valid,
  input  logic         aes_req_ready,
  output logic [127:0] aes_req_key,
  output logic [127:0] aes_req_blk,
  input  logic         aes_rsp_valid,
  input  logic [127:0] aes_rsp_blk,
  output logic         irq
);
  localparam int DW    = 32;
  localparam int BW    = 128;
  localparam int WPB   = BW / DW;
  localparam int NSLOT = 4;
  localparam int FPW   = $clog2(FDEPTH);
  localparam int CW    = FPW + 1;
  localparam logic [31:0] KEEP = 32'h7C07_0000;
  localparam logic [31:0] STAT = 32'h0020_0000;

  typedef enum logic [2:0] {S_IDLE, S_B0, S_WAIT, S_KS, S_MAC, S_TAG} st_t;

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = be[b] ? n[8*b +: 8] : o[8*b +: 8];
    return r;
  endfunction

  logic [31:0]  ctrl_q, blk_q;
  logic [127:0] iv_q, mac_q, cur_key, ctr_q, run_mac, data_q;
  logic [127:0] key_q [NSLOT];
  st_t          st;
  logic         sent, aad_q, irq_q;
  logic [15:0]  rem;

  logic [31:0]    imem [FDEPTH];
  logic [31:0]    omem [FDEPTH];
  logic [FPW-1:0] iwp, irp, owp, orp;
  logic [CW-1:0]  icnt, ocnt;

  wire         busy   = ctrl_q[31];
  wire         ccm    = !ctrl_q[29];
  wire  [31:0] wv     = merge(ctrl_q, reg_wdata, reg_be);
  wire         cwr    = reg_wr && reg_addr == 5'd0 && !busy;
  wire         start  = cwr && wv[31];
  wire         take   = sent && aes_rsp_valid;
  wire  [2:0]  tle    = (ctrl_q[18:16] == 3'd0) ? 3'd1 : ctrl_q[18:16];
  wire         room   = icnt >= CW'(WPB) && ocnt <= CW'(FDEPTH - WPB);
  wire         pop4   = st == S_WAIT && rem != 16'd0 && room;
  wire         push4  = st == S_KS && take;
  wire [127:0] plain  = data_q ^ aes_rsp_blk;
  wire         fin_ctr = st == S_WAIT && rem == 16'd0 && !ccm;
  wire         fin_tag = st == S_TAG && take;
  wire         fin    = fin_ctr || fin_tag;
  wire         tag_ok = (run_mac ^ aes_rsp_blk) == mac_q;
  wire         in_push = in_wr && !in_full;
  wire         out_pop = out_rd && !out_empty;

  wire [127:0] b0 = {8'h02 | {1'b0, aad_q, tle, 3'b000}, ctr_q[119:24], 4'h0, rem, 4'h0};

  logic [127:0] din;
  always_comb
    for (int w = 0; w < WPB; w++) din[DW*w +: DW] = imem[irp + FPW'(w)];

  always_comb begin
    case (st)
      S_B0:    aes_req_blk = b0;
      S_KS:    aes_req_blk = ctr_q;
      S_MAC:   aes_req_blk = run_mac;
      S_TAG:   aes_req_blk = {ctr_q[127:24], 24'h0};
      default: aes_req_blk = '0;
    endcase
  end

  assign aes_req_valid = (st == S_B0 || st == S_KS || st == S_MAC || st == S_TAG) && !sent;
  assign aes_req_key   = cur_key;
  assign ctrl_rd       = ctrl_q;
  assign irq           = irq_q;
  assign in_full       = icnt == CW'(FDEPTH);
  assign out_empty     = ocnt == '0;
  assign out_data      = omem[orp];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q   <= '0;
      iv_q    <= '0;
      mac_q   <= '0;
      cur_key <= '0;
      for (int s = 0; s < NSLOT; s++) key_q[s] <= '0;
    end else begin
      if (reg_wr) begin
        if (reg_addr == 5'd1) blk_q <= merge(blk_q, reg_wdata, reg_be);
        for (int w = 0; w < WPB; w++) begin
          if (reg_addr == 5'(4 + w))
            iv_q[DW*w +: DW] <= merge(iv_q[DW*w +: DW], reg_wdata, reg_be);
          if (reg_addr == 5'(8 + w))
            mac_q[DW*w +: DW] <= merge(mac_q[DW*w +: DW], reg_wdata, reg_be);
          for (int s = 0; s < NSLOT; s++)
            if (reg_addr == 5'(16 + WPB*s + w))
              key_q[s][DW*w +: DW] <= merge(key_q[s][DW*w +: DW], reg_wdata, reg_be);
        end
      end
      if (cwr && wv[24]) cur_key <= key_q[wv[27:26]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      st      <= S_IDLE;
      sent    <= 1'b0;
      irq_q   <= 1'b0;
      rem     <= '0;
      aad_q   <= 1'b0;
      ctr_q   <= '0;
      run_mac <= '0;
      data_q  <= '0;
    end else begin
      irq_q <= fin && ctrl_q[30];
      if (cwr) ctrl_q <= (wv & KEEP) | (ctrl_q & STAT) | {wv[31], 31'b0};
      if (fin) begin
        ctrl_q[31] <= 1'b0;
        ctrl_q[21] <= fin_tag && tag_ok;
      end
      if (aes_req_valid && aes_req_ready) sent <= 1'b1;
      if (take) sent <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rem     <= blk_q[31:16];
          aad_q   <= |blk_q[15:0];
          run_mac <= '0;
          ctr_q   <= wv[29] ? iv_q : {8'h02, iv_q[95:0], 24'h000001};
          st      <= wv[29] ? S_WAIT : S_B0;
        end
        S_B0: if (take) begin
          run_mac <= aes_rsp_blk;
          st      <= S_WAIT;
        end
        S_WAIT: begin
          if (rem == 16'd0) st <= ccm ? S_TAG : S_IDLE;
          else if (room) begin
            data_q <= din;
            st     <= S_KS;
          end
        end
        S_KS: if (take) begin
          ctr_q <= ctr_q + 128'd1;
          if (ccm) begin
            run_mac <= run_mac ^ plain;
            st      <= S_MAC;
          end else begin
            rem <= rem - 16'd1;
            st  <= S_WAIT;
          end
        end
        S_MAC: if (take) begin
          run_mac <= aes_rsp_blk;
          rem     <= rem - 16'd1;
          st      <= S_WAIT;
        end
        S_TAG: if (take) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iwp  <= '0;
      irp  <= '0;
      owp  <= '0;
      orp  <= '0;
      icnt <= '0;
      ocnt <= '0;
    end else begin
      if (in_push) iwp <= iwp + FPW'(1);
      if (pop4)    irp <= irp + FPW'(WPB);
      if (push4)   owp <= owp + FPW'(WPB);
      if (out_pop) orp <= orp + FPW'(1);
      icnt <= icnt + CW'(in_push) - (pop4 ? CW'(WPB) : CW'(0));
      ocnt <= ocnt + (push4 ? CW'(WPB) : CW'(0)) - CW'(out_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (in_push) imem[iwp] <= in_data;
    if (push4)
      for (int w = 0; w < WPB; w++) omem[owp + FPW'(w)] <= plain[DW*w +: DW];
  end
endmodule

// File: rtl/aes_ccm_seq_chk.sv
module aes_ccm_seq_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_wr,
  input logic [4:0]   reg_addr,
  input logic [31:0]  reg_wdata,
  input logic [3:0]   reg_be,
  input logic [31:0]  ctrl_rd,
  input logic         aes_req_valid,
  input logic         aes_req_ready,
  input logic [127:0] aes_req_blk,
  input logic         irq
);
  a_r13_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    aes_req_valid && !aes_req_ready |=> aes_req_valid && $stable(aes_req_blk));

  a_r2_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_rd[31]) |-> $past(reg_wr && reg_addr == 5'd0 && reg_be[3] && reg_wdata[31]));

  a_r12_irq_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ctrl_rd[31]) && !ctrl_rd[31]);

  a_r12_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_rd[31] |-> !aes_req_valid);

  a_r3_ctr_status: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_rd[31]) && ctrl_rd[29] |-> !ctrl_rd[21]);
endmodule

bind aes_ccm_seq aes_ccm_seq_chk u_chk (.*);

// File: tb/aes_ccm_seq_bench.sv
module aes_ccm_seq_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0] reg_be = '0;
  logic [31:0] ctrl_rd;
  logic in_wr = 1'b0;
  logic [31:0] in_data = '0;
  logic in_full;
  logic out_rd = 1'b0;
  logic [31:0] out_data;
  logic out_empty;
  logic aes_req_valid;
  logic aes_req_ready = 1'b0;
  logic [127:0] aes_req_key, aes_req_blk;
  logic aes_rsp_valid = 1'b0;
  logic [127:0] aes_rsp_blk = '0;
  logic irq;

  aes_ccm_seq u_aes_ccm_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_be(reg_be), .ctrl_rd(ctrl_rd),
    .in_wr(in_wr), .in_data(in_data), .in_full(in_full),
    .out_rd(out_rd), .out_data(out_data), .out_empty(out_empty),
    .aes_req_valid(aes_req_valid), .aes_req_ready(aes_req_ready),
    .aes_req_key(aes_req_key), .aes_req_blk(aes_req_blk),
    .aes_rsp_valid(aes_rsp_valid), .aes_rsp_blk(aes_rsp_blk), .irq(irq)
  );

  // stimulus: [15:14] mode [13:12] slot [11:8] blocks [7:5] tag len [4] aux flag
  //           [3] irq enable [2] corrupt tag ; expected: [1] tag ok ; [0] stall test
  localparam logic [15:0] VEC [0:5] = '{16'h9308, 16'hE501, 16'h026A,
                                         16'h341C, 16'h11E2, 16'h604A};

  int checks = 0, errors = 0, seed = 0;
  int cyc = 0, req_n = 0, irq_n = 0, lat = 0;
  bit pend = 1'b0;
  logic [127:0] rsp_hold = '0;
  logic [127:0] log_blk [256];
  logic [127:0] log_key [256];
  logic [127:0] key_m [4];
  logic [127:0] iv_m = '0;

  function automatic logic [127:0] fenc(input logic [127:0] k, input logic [127:0] b);
    return {b[100:0], b[127:101]} ^ k ^ {4{32'h9E37_79B9}};
  endfunction

  function automatic logic [31:0] dw(input int i);
    return 32'h3C5A_96E1 ^ (32'(i) * 32'h0101_0107) ^ {24'h0, 8'(seed)};
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    aes_req_ready <= (cyc % 3) != 1;
    aes_rsp_valid <= 1'b0;
    if (irq) irq_n <= irq_n + 1;
    if (aes_req_valid && aes_req_ready) begin
      pend <= 1'b1;
      lat <= 2;
      rsp_hold <= fenc(aes_req_key, aes_req_blk);
      log_blk[req_n % 256] <= aes_req_blk;
      log_key[req_n % 256] <= aes_req_key;
      req_n <= req_n + 1;
    end else if (pend) begin
      if (lat == 0) begin
        aes_rsp_valid <= 1'b1;
        aes_rsp_blk <= rsp_hold;
        pend <= 1'b0;
      end else lat <= lat - 1;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wreg(input int a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 5'(a); reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run(input logic [1:0] mode, input logic [1:0] slot, input int nblk,
                     input logic [2:0] tl, input bit lo, input bit ie, input bit bad,
                     input bit okx, input bit hold);
    logic [127:0] k, c, m, ks, p, d, b0, tag, ctrz, mac1;
    logic [31:0] ew [64];
    logic [31:0] v;
    logic [2:0] tle;
    bit ccm;
    int nw, rb, ib, pi, po, guard;
    seed++;
    ccm = !mode[1];
    nw = 4 * nblk;
    k = key_m[slot];
    tle = (tl == 3'd0) ? 3'd1 : tl;
    c = ccm ? {8'h02, iv_m[95:0], 24'h000001} : iv_m;
    b0 = {8'h02 | {1'b0, lo, tle, 3'b000}, iv_m[95:0], 4'h0, 16'(nblk), 4'h0};
    m = fenc(k, b0);
    mac1 = '0;
    for (int b = 0; b < nblk; b++) begin
      d = {dw(4*b+3), dw(4*b+2), dw(4*b+1), dw(4*b)};
      ks = fenc(k, c);
      p = d ^ ks;
      for (int w = 0; w < 4; w++) ew[4*b+w] = p[32*w +: 32];
      if (b == 0) mac1 = m ^ p;
      if (ccm) m = fenc(k, m ^ p);
      c = c + 128'd1;
    end
    ctrz = {8'h02, iv_m[95:0], 24'h0};
    tag = m ^ fenc(k, ctrz);
    if (ccm)
      for (int w = 0; w < 4; w++) wreg(8 + w, tag[32*w +: 32] ^ ((bad && w == 0) ? 32'h1 : 32'h0), 4'hF);
    wreg(1, {16'(nblk), lo ? 16'h0010 : 16'h0000}, 4'hF);
    v = {1'b0, ie, mode, slot, 1'b0, 1'b1, 5'b0, tl, 16'b0};
    wreg(0, v, 4'hF);
    rb = req_n; ib = irq_n;
    wreg(0, v | 32'h8000_0000, 4'hF);
    chk(ctrl_rd[31] == 1'b1, "R2 busy after start", 128'(ctrl_rd), 128'h8000_0000);
    pi = 0; po = 0;
    if (hold) begin
      while (pi < nw) begin
        @(negedge clk);
        in_wr = 1'b0;
        if (!in_full) begin in_wr = 1'b1; in_data = dw(pi); pi++; end
      end
      @(negedge clk); in_wr = 1'b0;
      repeat (60) @(negedge clk);
      chk(req_n - rb == 4, "R11 stall with full output", 128'(req_n - rb), 128'd4);
      chk(ctrl_rd[31] == 1'b1, "R11 busy while stalled", 128'(ctrl_rd), 128'h8000_0000);
      wreg(0, 32'h8000_0000, 4'hF);
      chk((ctrl_rd & ~32'h0020_0000) == {1'b1, ie, mode, slot, 7'b0, tl, 16'b0},
          "R2 write while busy ignored", 128'(ctrl_rd), 128'({1'b1, ie, mode, slot, 7'b0, tl, 16'b0}));
    end
    guard = 0;
    while ((po < nw || ctrl_rd[31]) && guard < 5000) begin
      @(negedge clk);
      in_wr = 1'b0; out_rd = 1'b0; guard++;
      if (pi < nw && !in_full) begin in_wr = 1'b1; in_data = dw(pi); pi++; end
      if (!out_empty) begin
        out_rd = 1'b1;
        if (po < nw) chk(out_data == ew[po], ccm ? "R6 ccm output word" : "R3 ctr output word",
                         128'(out_data), 128'(ew[po]));
        else chk(1'b0, "R3 extra output word", 128'(out_data), 128'h0);
        po++;
      end
    end
    @(negedge clk); in_wr = 1'b0; out_rd = 1'b0;
    repeat (3) @(negedge clk);
    chk(ctrl_rd[31] == 1'b0, "R2 busy clears at completion", 128'(ctrl_rd), 128'h0);
    chk(ctrl_rd[21] == okx, ccm ? "R8 tag status" : "R3 ctr status clear", 128'(ctrl_rd[21]), 128'(okx));
    chk(irq_n - ib == int'(ie), "R12 interrupt pulses", 128'(irq_n - ib), 128'(ie));
    chk(log_key[rb % 256] == k, "R4 key from slot", log_key[rb % 256], k);
    if (ccm) begin
      chk(log_blk[rb % 256] == b0, (tl == 3'd0) ? "R9 seed block zero length" : "R5 seed block",
          log_blk[rb % 256], b0);
      chk(req_n - rb == 2 * nblk + 2, "R7 request count", 128'(req_n - rb), 128'(2 * nblk + 2));
      if (nblk > 0) begin
        chk(log_blk[(rb+1) % 256] == {8'h02, iv_m[95:0], 24'h000001}, "R6 first counter",
            log_blk[(rb+1) % 256], {8'h02, iv_m[95:0], 24'h000001});
        chk(log_blk[(rb+2) % 256] == mac1, "R7 mac chaining", log_blk[(rb+2) % 256], mac1);
      end
      chk(log_blk[(req_n-1) % 256] == ctrz, "R8 final counter", log_blk[(req_n-1) % 256], ctrz);
    end else if (nblk > 0) begin
      chk(log_blk[rb % 256] == iv_m, "R3 first counter", log_blk[rb % 256], iv_m);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=hung expected=complete");
    summary();
    $finish;
  end

  initial begin
    for (int s = 0; s < 4; s++) key_m[s] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl_rd == 32'h0, "R1 control after reset", 128'(ctrl_rd), 128'h0);
    chk(!in_full && out_empty, "R1 fifo flags after reset", 128'({in_full, out_empty}), 128'h1);
    chk(!irq && !aes_req_valid, "R1 quiet after reset", 128'({irq, aes_req_valid}), 128'h0);

    run(2'd2, 2'd0, 1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(log_key[(req_n-1) % 256] == '0 && log_blk[(req_n-1) % 256] == '0, "R1 cleared key and vector",
        log_key[(req_n-1) % 256] | log_blk[(req_n-1) % 256], 128'h0);

    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 4; w++) begin
        wreg(16 + 4*s + w, 32'hC0DE_0000 ^ (32'(s) << 12) ^ (32'(w) * 32'h0011_0101), 4'hF);
        key_m[s][32*w +: 32] = 32'hC0DE_0000 ^ (32'(s) << 12) ^ (32'(w) * 32'h0011_0101);
      end
    wreg(4, 32'h1111_1111, 4'hF);
    wreg(5, 32'h2468_ACE0, 4'hF);
    wreg(6, 32'hFEDC_BA98, 4'hF);
    wreg(7, 32'h7654_3210, 4'hF);
    wreg(4, 32'hAAAA_BBBB, 4'b0101);
    iv_m = {32'h7654_3210, 32'hFEDC_BA98, 32'h2468_ACE0, 32'h11AA_11BB};
    run(2'd2, 2'd1, 1, 3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    chk(log_blk[(req_n-1) % 256][31:0] == 32'h11AA_11BB, "R10 masked vector write",
        128'(log_blk[(req_n-1) % 256][31:0]), 128'h11AA_11BB);

    for (int i = 0; i < 6; i++)
      run(VEC[i][15:14], VEC[i][13:12], int'(VEC[i][11:8]), VEC[i][7:5], VEC[i][4],
          VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);

    summary();
    $finish;
  end
endmodule